// File: doc/BRIEF.md
# Software Interrupt Source Tracker

This block lets processors raise interrupts on one another. A full-word write to the trigger address names an interrupt number and picks a set of target processors. For each target, the block then records the writer as one more source of that interrupt. The state is kept as a bitmap of requesting processors for every (interrupt, target) pair. An interrupt counts as pending for a target while its bitmap for that target is non-empty. The per-target pending flags leave the block on a flat vector, which feeds an external arbiter that picks what to acknowledge.

When a processor acknowledges an interrupt number, the block takes the lowest-numbered source out of that bitmap. It answers one cycle later with the number, and places the source index in a field above it. Software can also set or clear source bits directly with byte writes, and can read every bitmap back. The per-processor enable bits of these interrupts can be set but never cleared. Pending writes of the ordinary kind do nothing for these interrupt numbers.

Each register write carries the writer's processor number as a sideband. The write and acknowledge ports have no back-pressure, so the block accepts every strobe in the cycle it is raised. An acknowledge always gets exactly one response, in the next cycle. `NUM_CPU` is a power of two from 2 to 8, and `NUM_SGI` is a multiple of 8.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset every source bitmap and every enable bit is zero, `sgi_pending` is all zero and `rsp_valid` is low.
- R2: A write of `wr_data` to address 0xF00 triggers the interrupt whose number is in bits 9:0, using target list bits 23:16 and filter bits 25:24. In each selected target's bitmap for that number, bit `wr_cpu` is set. Numbers of `NUM_SGI` or above change nothing.
- R3: Filter 0 selects the CPUs named in the target list. Filter 1 selects every CPU except the writer, filter 2 only the writer, and filter 3 every CPU.
- R4: An acknowledge (`ack_valid`) of a number below `NUM_SGI` whose bitmap for `ack_cpu` is non-empty clears the lowest set source bit. One cycle later it returns `rsp_id` = number | (source << 10).
- R5: Bit `cpu*NUM_SGI + n` of `sgi_pending` is high exactly while the bitmap of interrupt n for that CPU is non-empty. It stays high until the last source has been consumed.
- R6: An acknowledge of an empty bitmap returns 0x3FF and changes nothing. An acknowledge of a number of `NUM_SGI` or above returns that number unchanged. `rsp_valid` is high exactly in the cycle after each acknowledge.
- R7: A write to 0xF10+n clears the bits of `wr_data[7:0]` in the writer's own bitmap for interrupt n. It leaves other CPUs' bitmaps unchanged.
- R8: A write to 0xF20+n ORs `wr_data[7:0]` into the writer's own bitmap for interrupt n.
- R9: `rd_data` at 0xF10+n or 0xF20+n is the current bitmap of interrupt n for `rd_cpu`. At 0x200+b it is the pending flags of interrupts 8b..8b+7 for `rd_cpu`, with bit 0 for the lowest number.
- R10: A write to 0x100+b sets the writer's enable bits of interrupts 8b..8b+7 whatever the data is. `rd_data` at 0x100+b returns them.
- R11: Writes to 0x180+b (clear enable), 0x200+b (set pending) and 0x280+b (clear pending) change no enable bit and no bitmap.
- R12: When a write and an acknowledge come in the same cycle, the write takes effect first. The acknowledge then sees the updated bitmaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_cpu | input | CPU_W | Processor number of the writer |
| wr_addr | input | 12 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_cpu | input | CPU_W | Processor whose view is read |
| rd_addr | input | 12 | Read byte address |
| rd_data | output | 8 | Combinational read data |
| ack_valid | input | 1 | Acknowledge request |
| ack_cpu | input | CPU_W | Acknowledging processor |
| ack_id | input | 10 | Interrupt number being acknowledged |
| rsp_valid | output | 1 | Acknowledge response valid |
| rsp_id | output | 13 | Returned number with the source in bits 12:10 |
| sgi_pending | output | NUM_CPU*NUM_SGI | Pending flag per target and interrupt |

## Verification
The hardest case to reach is a trigger and an acknowledge of the same interrupt and target in one cycle, when that bitmap was empty beforehand. Only the ordering rule then stops the answer from being spurious. The bench drives both strobes in one cycle and expects the new source to be returned and the bitmap to end up empty. It also builds bitmaps with several sources from different writers and filters, so that repeated acknowledges must consume the sources lowest first and drop pending only on the last one.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam int ADDR_W = 12;
  localparam int ID_W   = 10;
  localparam int SRCF_W = 3;
  localparam int RSP_W  = ID_W + SRCF_W;

  localparam logic [ADDR_W-1:0] ADDR_TRIG    = 12'hF00;
  localparam logic [ADDR_W-1:0] ADDR_SRC_CLR = 12'hF10;
  localparam logic [ADDR_W-1:0] ADDR_SRC_SET = 12'hF20;
  localparam logic [ADDR_W-1:0] ADDR_EN_SET  = 12'h100;
  localparam logic [ADDR_W-1:0] ADDR_EN_CLR  = 12'h180;
  localparam logic [ADDR_W-1:0] ADDR_PND_SET = 12'h200;
  localparam logic [ADDR_W-1:0] ADDR_PND_CLR = 12'h280;

  localparam logic [RSP_W-1:0] RSP_SPURIOUS = 13'h3FF;

  typedef enum logic [1:0] {
    FLT_LIST   = 2'd0,
    FLT_OTHERS = 2'd1,
    FLT_SELF   = 2'd2,
    FLT_ALL    = 2'd3
  } tgt_filter_e;
endpackage

// File: rtl/sgi_target_decode.sv
module sgi_target_decode #(
  parameter int NUM_CPU = 8,
  parameter int CPU_W   = 3
) (
  input  sgi_pkg::tgt_filter_e filt,
  input  logic [7:0]           tlist,
  input  logic [CPU_W-1:0]     req_cpu,
  output logic [NUM_CPU-1:0]   targets
);
  import sgi_pkg::*;

  logic [NUM_CPU-1:0] self_m;
  logic [NUM_CPU-1:0] list_m;

  always_comb begin
    self_m = '0;
    self_m[req_cpu] = 1'b1;
    for (int i = 0; i < NUM_CPU; i++) list_m[i] = tlist[i];
  end

  always_comb begin
    unique case (filt)
      FLT_LIST:   targets = list_m;
      FLT_OTHERS: targets = ~self_m;
      FLT_SELF:   targets = self_m;
      default:    targets = '1;
    endcase
  end
endmodule

// File: rtl/sgi_lowest_src.sv
module sgi_lowest_src #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/sgi_src_bank.sv
module sgi_src_bank #(
  parameter int NUM_CPU  = 8,
  parameter int NUM_SGI  = 16,
  parameter int CPU_W    = 3,
  parameter int SGI_W    = 4,
  parameter int EN_BYTES = 2,
  parameter int BYTE_W   = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       trig_en,
  input  logic [SGI_W-1:0]           trig_sgi,
  input  logic [CPU_W-1:0]           trig_src,
  input  logic                       dir_set,
  input  logic                       dir_clr,
  input  logic [SGI_W-1:0]           dir_sgi,
  input  logic [NUM_CPU-1:0]         dir_bits,
  input  logic                       en_set,
  input  logic [BYTE_W-1:0]          en_byte,
  input  logic                       ack_req,
  input  logic [SGI_W-1:0]           ack_sgi,
  output logic                       ack_found,
  output logic [CPU_W-1:0]           ack_src,
  output logic [NUM_SGI*NUM_CPU-1:0] src_map,
  output logic [NUM_SGI-1:0]         en_bits,
  output logic [NUM_SGI-1:0]         pend_bits
);
  logic [NUM_SGI-1:0][NUM_CPU-1:0] map_q, map_w, map_d;
  logic [NUM_CPU-1:0] req_bit, ack_vec, ack_clr;
  logic [NUM_SGI-1:0] en_q;

  always_comb begin
    req_bit = '0;
    req_bit[trig_src] = 1'b1;
  end

  // write stage: applied before any acknowledge of the same cycle
  always_comb begin
    for (int s = 0; s < NUM_SGI; s++) begin
      map_w[s] = map_q[s];
      if (trig_en && trig_sgi == SGI_W'(s)) map_w[s] = map_w[s] | req_bit;
      if (dir_set && dir_sgi == SGI_W'(s))  map_w[s] = map_w[s] | dir_bits;
      if (dir_clr && dir_sgi == SGI_W'(s))  map_w[s] = map_w[s] & ~dir_bits;
    end
  end

  assign ack_vec = map_w[ack_sgi];

  sgi_lowest_src #(.N(NUM_CPU), .IDX_W(CPU_W)) u_pick (
    .vec   (ack_vec),
    .found (ack_found),
    .idx   (ack_src)
  );

  always_comb begin
    ack_clr = '0;
    ack_clr[ack_src] = ack_found;
  end

  // acknowledge stage: consumes one source from the written state
  always_comb begin
    for (int s = 0; s < NUM_SGI; s++) begin
      map_d[s] = map_w[s];
      if (ack_req && ack_sgi == SGI_W'(s)) map_d[s] = map_w[s] & ~ack_clr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) map_q <= '0;
    else        map_q <= map_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else begin
      for (int b = 0; b < EN_BYTES; b++) begin
        if (en_set && en_byte == BYTE_W'(b)) en_q[b*8 +: 8] <= '1;
      end
    end
  end

  always_comb begin
    for (int s = 0; s < NUM_SGI; s++) pend_bits[s] = |map_q[s];
  end

  assign src_map = map_q;
  assign en_bits = en_q;
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch #(
  parameter int NUM_CPU    = 8,
  parameter int NUM_SGI    = 16,
  localparam int CPU_W     = $clog2(NUM_CPU),
  localparam int SGI_W     = $clog2(NUM_SGI),
  localparam int EN_BYTES  = NUM_SGI / 8,
  localparam int BYTE_W    = (EN_BYTES > 1) ? $clog2(EN_BYTES) : 1,
  localparam int MAP_W     = NUM_SGI * NUM_CPU
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [CPU_W-1:0]           wr_cpu,
  input  logic [11:0]                wr_addr,
  input  logic [31:0]                wr_data,
  input  logic [CPU_W-1:0]           rd_cpu,
  input  logic [11:0]                rd_addr,
  output logic [7:0]                 rd_data,
  input  logic                       ack_valid,
  input  logic [CPU_W-1:0]           ack_cpu,
  input  logic [9:0]                 ack_id,
  output logic                       rsp_valid,
  output logic [12:0]                rsp_id,
  output logic [MAP_W-1:0]           sgi_pending
);
  import sgi_pkg::*;

  // write decode
  logic [11:0] clr_off, set_off, en_off;
  logic trig_w, clr_w, set_w, en_w;
  logic [SGI_W-1:0] trig_sgi, dir_sgi;
  logic [NUM_CPU-1:0] tgt_mask;

  assign clr_off = wr_addr - ADDR_SRC_CLR;
  assign set_off = wr_addr - ADDR_SRC_SET;
  assign en_off  = wr_addr - ADDR_EN_SET;

  assign trig_w = wr_en && (wr_addr == ADDR_TRIG) && (wr_data[9:0] < 10'(NUM_SGI));
  assign clr_w  = wr_en && (wr_addr >= ADDR_SRC_CLR) && (clr_off < 12'(NUM_SGI));
  assign set_w  = wr_en && (wr_addr >= ADDR_SRC_SET) && (set_off < 12'(NUM_SGI));
  assign en_w   = wr_en && (wr_addr >= ADDR_EN_SET) && (en_off < 12'(EN_BYTES));

  assign trig_sgi = wr_data[SGI_W-1:0];
  assign dir_sgi  = clr_w ? clr_off[SGI_W-1:0] : set_off[SGI_W-1:0];

  sgi_target_decode #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_tgt (
    .filt    (tgt_filter_e'(wr_data[25:24])),
    .tlist   (wr_data[23:16]),
    .req_cpu (wr_cpu),
    .targets (tgt_mask)
  );

  // acknowledge decode
  logic ack_ok;
  assign ack_ok = ack_valid && (ack_id < 10'(NUM_SGI));

  logic [MAP_W-1:0]   src_all  [NUM_CPU];
  logic [NUM_SGI-1:0] en_all   [NUM_CPU];
  logic [NUM_SGI-1:0] pend_all [NUM_CPU];
  logic               found_v  [NUM_CPU];
  logic [CPU_W-1:0]   srcidx_v [NUM_CPU];

  for (genvar t = 0; t < NUM_CPU; t++) begin : g_bank
    sgi_src_bank #(
      .NUM_CPU(NUM_CPU), .NUM_SGI(NUM_SGI), .CPU_W(CPU_W), .SGI_W(SGI_W),
      .EN_BYTES(EN_BYTES), .BYTE_W(BYTE_W)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig_en   (trig_w && tgt_mask[t]),
      .trig_sgi  (trig_sgi),
      .trig_src  (wr_cpu),
      .dir_set   (set_w && wr_cpu == CPU_W'(t)),
      .dir_clr   (clr_w && wr_cpu == CPU_W'(t)),
      .dir_sgi   (dir_sgi),
      .dir_bits  (wr_data[NUM_CPU-1:0]),
      .en_set    (en_w && wr_cpu == CPU_W'(t)),
      .en_byte   (en_off[BYTE_W-1:0]),
      .ack_req   (ack_ok && ack_cpu == CPU_W'(t)),
      .ack_sgi   (ack_id[SGI_W-1:0]),
      .ack_found (found_v[t]),
      .ack_src   (srcidx_v[t]),
      .src_map   (src_all[t]),
      .en_bits   (en_all[t]),
      .pend_bits (pend_all[t])
    );
    assign sgi_pending[t*NUM_SGI +: NUM_SGI] = pend_all[t];
  end

  // acknowledge response, one cycle after the request
  logic [12:0] rsp_nxt;
  always_comb begin
    if (!ack_ok)                rsp_nxt = {3'b000, ack_id};
    else if (found_v[ack_cpu])  rsp_nxt = {SRCF_W'(srcidx_v[ack_cpu]), ack_id};
    else                        rsp_nxt = RSP_SPURIOUS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_id    <= '0;
    end else begin
      rsp_valid <= ack_valid;
      if (ack_valid) rsp_id <= rsp_nxt;
    end
  end

  // read mux
  logic [11:0] rc_off, rs_off, re_off, rp_off;
  assign rc_off = rd_addr - ADDR_SRC_CLR;
  assign rs_off = rd_addr - ADDR_SRC_SET;
  assign re_off = rd_addr - ADDR_EN_SET;
  assign rp_off = rd_addr - ADDR_PND_SET;

  always_comb begin
    rd_data = '0;
    if (rd_addr >= ADDR_SRC_CLR && rc_off < 12'(NUM_SGI))
      rd_data = 8'(src_all[rd_cpu][rc_off[SGI_W-1:0]*NUM_CPU +: NUM_CPU]);
    else if (rd_addr >= ADDR_SRC_SET && rs_off < 12'(NUM_SGI))
      rd_data = 8'(src_all[rd_cpu][rs_off[SGI_W-1:0]*NUM_CPU +: NUM_CPU]);
    else if (rd_addr >= ADDR_EN_SET && re_off < 12'(EN_BYTES))
      rd_data = en_all[rd_cpu][re_off[BYTE_W-1:0]*8 +: 8];
    else if (rd_addr >= ADDR_PND_SET && rp_off < 12'(EN_BYTES))
      rd_data = pend_all[rd_cpu][rp_off[BYTE_W-1:0]*8 +: 8];
  end

  logic unused_bits;
  assign unused_bits = ^{wr_data[31:26], wr_data[15:10], wr_data[7:0], clr_off, set_off,
                         en_off, rc_off, rs_off, re_off, rp_off};
endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
  parameter int NUM_CPU   = 8,
  parameter int NUM_SGI   = 16,
  localparam int CPU_W    = $clog2(NUM_CPU),
  localparam int SGI_W    = $clog2(NUM_SGI),
  localparam int EN_BYTES = NUM_SGI / 8,
  localparam int MAP_W    = NUM_SGI * NUM_CPU
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [CPU_W-1:0]  wr_cpu,
  input logic [11:0]       wr_addr,
  input logic [31:0]       wr_data,
  input logic              ack_valid,
  input logic [9:0]        ack_id,
  input logic              rsp_valid,
  input logic [12:0]       rsp_id,
  input logic [MAP_W-1:0]  sgi_pending
);
  logic ign_wr;
  assign ign_wr = wr_en && (
      (wr_addr >= 12'h180 && wr_addr < 12'h180 + 12'(EN_BYTES)) ||
      (wr_addr >= 12'h200 && wr_addr < 12'h200 + 12'(EN_BYTES)) ||
      (wr_addr >= 12'h280 && wr_addr < 12'h280 + 12'(EN_BYTES)) ||
      (wr_addr >= 12'h100 && wr_addr < 12'h100 + 12'(EN_BYTES)));

  a_r6_rsp_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> rsp_valid);

  a_r6_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_valid |=> !rsp_valid);

  a_r6_high_id_echo: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_id >= 10'(NUM_SGI)) |=> (rsp_id == {3'b000, $past(ack_id)}));

  a_r4_id_field_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_id < 10'(NUM_SGI)) |=>
      ((rsp_id[9:0] == $past(ack_id)) || (rsp_id == 13'h3FF)));

  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !ack_valid) |=> $stable(sgi_pending));

  a_r11_inert_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (ign_wr && !ack_valid) |=> $stable(sgi_pending));

  a_r2_wide_id_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 12'hF00 && wr_data[9:0] >= 10'(NUM_SGI) && !ack_valid)
      |=> $stable(sgi_pending));

  a_r3_self_target_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 12'hF00 && wr_data[25:24] == 2'd2 &&
     wr_data[9:0] < 10'(NUM_SGI) && !ack_valid)
      |=> sgi_pending[$past(wr_cpu)*NUM_SGI + $past(wr_data[SGI_W-1:0])]);
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NUM_CPU(NUM_CPU), .NUM_SGI(NUM_SGI)) u_chk (.*);

// File: tb/test_sgi_dispatch.sv
`timescale 1ns/1ps
module test_sgi_dispatch;
  localparam int NC = 8;
  localparam int NS = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_cpu = '0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0] rd_cpu = '0;
  logic [11:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic ack_valid = 1'b0;
  logic [2:0] ack_cpu = '0;
  logic [9:0] ack_id = '0;
  logic rsp_valid;
  logic [12:0] rsp_id;
  logic [NC*NS-1:0] sgi_pending;

  always #4 clk = ~clk;

  sgi_dispatch #(.NUM_CPU(NC), .NUM_SGI(NS)) i_sgi_dispatch (
    .clk, .rst_n, .wr_en, .wr_cpu, .wr_addr, .wr_data, .rd_cpu, .rd_addr, .rd_data,
    .ack_valid, .ack_cpu, .ack_id, .rsp_valid, .rsp_id, .sgi_pending
  );

  int n_chk = 0;
  int n_fail = 0;
  bit chk_on = 0;

  // reference model
  bit [7:0] mdl_src [NC][NS];
  bit       nxt_v = 0, exp_v = 0;
  bit [12:0] nxt_id = '0, exp_id = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_write(input logic [11:0] a, input logic [31:0] d, input int c);
    bit [7:0] tg;
    int id;
    if (a == 12'hF00) begin
      id = int'(d[9:0]);
      if (id < NS) begin
        case (d[25:24])
          2'd0: tg = d[23:16];
          2'd1: tg = 8'hFF & ~(8'h1 << c);
          2'd2: tg = 8'h1 << c;
          default: tg = 8'hFF;
        endcase
        for (int t = 0; t < NC; t++) if (tg[t]) mdl_src[t][id] |= (8'h1 << c);
      end
    end else if (a >= 12'hF10 && a < 12'hF20) begin
      mdl_src[c][a - 12'hF10] &= ~d[7:0];
    end else if (a >= 12'hF20 && a < 12'hF30) begin
      mdl_src[c][a - 12'hF20] |= d[7:0];
    end
  endtask

  task automatic model_ack(input int c, input logic [9:0] id);
    int s;
    nxt_v = 1;
    if (id >= NS) begin
      nxt_id = {3'b000, id};
    end else if (mdl_src[c][id] == 0) begin
      nxt_id = 13'h3FF;
    end else begin
      s = 0;
      while (!mdl_src[c][id][s]) s++;
      mdl_src[c][id][s] = 1'b0;
      nxt_id = {3'(s), id};
    end
  endtask

  always @(posedge clk) begin
    exp_v  <= nxt_v;
    exp_id <= nxt_id;
  end

  // compare every clock
  always @(negedge clk) begin
    if (chk_on) begin
      logic [NC*NS-1:0] ev;
      for (int t = 0; t < NC; t++)
        for (int s = 0; s < NS; s++) ev[t*NS+s] = (mdl_src[t][s] != 0);
      chk(sgi_pending == ev, "R5 pending vector", 32'(sgi_pending[31:0]), 32'(ev[31:0]));
      chk(rsp_valid == exp_v, "R6 response valid", 32'(rsp_valid), 32'(exp_v));
      if (exp_v) chk(rsp_id == exp_id, "R4 response id", 32'(rsp_id), 32'(exp_id));
    end
  end

  task automatic cyc(input bit we, input logic [11:0] wa, input logic [31:0] wd, input int wc,
                     input bit av, input int ac, input logic [9:0] ai);
    @(negedge clk); #1;
    wr_en = we; wr_addr = wa; wr_data = wd; wr_cpu = 3'(wc);
    ack_valid = av; ack_cpu = 3'(ac); ack_id = ai;
    if (we) model_write(wa, wd, wc);
    if (av) model_ack(ac, ai); else nxt_v = 0;
    @(posedge clk); #1;
    wr_en = 1'b0; ack_valid = 1'b0; nxt_v = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input int c);
    cyc(1, a, d, c, 0, 0, 10'd0);
  endtask

  task automatic ack(input int c, input logic [9:0] id);
    cyc(0, 12'h0, 32'h0, 0, 1, c, id);
  endtask

  task automatic rdchk(input logic [11:0] a, input int c, input logic [7:0] exp, input string tag);
    @(negedge clk); #2;
    rd_addr = a; rd_cpu = 3'(c);
    #1;
    chk(rd_data == exp, tag, 32'(rd_data), 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int t = 0; t < NC; t++) for (int s = 0; s < NS; s++) mdl_src[t][s] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(sgi_pending == '0, "R1 pending after reset", 32'(sgi_pending[31:0]), 0);
    chk(rsp_valid == 1'b0, "R1 no response after reset", 32'(rsp_valid), 0);
    chk_on = 1;
    rdchk(12'h100, 0, 8'h00, "R1 enable byte after reset");
    rdchk(12'hF13, 5, 8'h00, "R1 bitmap after reset");

    // R2 list filter: cpu3, list {0,2}, id 2
    wr(12'hF00, 32'h0005_0002, 3);
    rdchk(12'hF12, 0, 8'h08, "R2 list target cpu0 (R9 read)");
    rdchk(12'hF22, 2, 8'h08, "R2 list target cpu2 via set alias R9");
    rdchk(12'hF12, 1, 8'h00, "R2 unlisted cpu1");
    // R3 self filter from cpu1
    wr(12'hF00, 32'h0200_0002, 1);
    rdchk(12'hF12, 1, 8'h02, "R3 self filter");
    // R3 others filter from cpu5
    wr(12'hF00, 32'h0100_0002, 5);
    rdchk(12'hF12, 5, 8'h00, "R3 others excludes writer");
    rdchk(12'hF12, 0, 8'h28, "R3 others adds source 5");
    rdchk(12'hF12, 7, 8'h20, "R3 others reaches cpu7");
    // R3 filter 3 from cpu6, id 7, empty list
    wr(12'hF00, 32'h0300_0007, 6);
    rdchk(12'hF17, 6, 8'h40, "R3 all filter includes writer");
    rdchk(12'hF17, 3, 8'h40, "R3 all filter cpu3");
    // R2 wide id ignored
    wr(12'hF00, 32'h0300_0014, 0);
    rdchk(12'hF14, 0, 8'h00, "R2 id 20 ignored");

    // R4 lowest source first, R5 pending drops on last
    ack(0, 10'd2);
    ack(0, 10'd2);
    rdchk(12'h200, 0, 8'h80, "R5 cpu0 pending byte after draining sgi2");
    ack(0, 10'd2);  // R6 empty -> 0x3FF
    ack(3, 10'd40); // R6 high id echoed
    ack(1, 10'd2);
    ack(1, 10'd2);
    rdchk(12'hF12, 1, 8'h00, "R4 cpu1 sgi2 drained");

    // R8 / R7 direct source writes
    wr(12'hF24, 32'h0000_0081, 4);
    rdchk(12'hF24, 4, 8'h81, "R8 set source bits");
    rdchk(12'hF14, 4, 8'h81, "R9 clear alias reads bitmap");
    wr(12'hF14, 32'h0000_0001, 4);
    rdchk(12'hF14, 4, 8'h80, "R7 clear source bit");
    wr(12'hF14, 32'h0000_0080, 3);
    rdchk(12'hF14, 4, 8'h80, "R7 other cpu clear has no effect");

    // R10 / R11 enables and inert writes
    wr(12'h100, 32'h0000_0000, 2);
    rdchk(12'h100, 2, 8'hFF, "R10 set enable acts as all ones");
    rdchk(12'h100, 1, 8'h00, "R10 other cpu enable untouched");
    rdchk(12'h101, 2, 8'h00, "R10 other byte untouched");
    wr(12'h180, 32'h0000_00FF, 2);
    rdchk(12'h100, 2, 8'hFF, "R11 clear enable inert");
    wr(12'h200, 32'h0000_00FF, 2);
    rdchk(12'h200, 2, 8'h84, "R11 set pending inert (R9 pending read)");
    wr(12'h280, 32'h0000_00FF, 4);
    rdchk(12'hF14, 4, 8'h80, "R11 clear pending inert");
    rdchk(12'h200, 4, 8'h94, "R11 cpu4 pending byte");

    // R12 write then acknowledge in the same cycle
    cyc(1, 12'hF00, 32'h0200_0009, 1, 1, 1, 10'd9);
    rdchk(12'hF19, 1, 8'h00, "R12 same-cycle source consumed");
    ack(7, 10'd7);
    ack(7, 10'd2);
    ack(7, 10'd2);
    repeat (3) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule